// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block decides when an on-chip analog-to-digital converter wakes, tracks its input, takes its sample and converts. A 3-bit selector chooses where the start request comes from: one of three timer outputs, an external convert pin (straight or inverted), a self-pacing continuous mode, or a software start bit. A mode bit picks between one-edge operation, where a single rising edge runs the whole sequence, and two-edge operation, where the rising edge wakes the converter and opens acquisition and the following falling edge closes acquisition and starts conversion.

The converter itself is not part of the block. Its wake-up, acquisition and conversion times are modelled as fixed cycle counts. The block drives one strobe per phase, a busy flag and a one-cycle completion pulse. The converter shuts itself down after each conversion, so each new request pays the wake-up time again. The exception is continuous mode, where the converter stays awake between conversions and the wake-up phase is skipped after the first one.

Top module: `adc_trig_seq`

## Requirements
- R1: While and right after synchronous reset, pwr_up, acquire, convert, busy, done and cfg_err are all low.
- R2: Selector 3'b000, 3'b001 and 3'b010 take the start request from tmr_out[0], tmr_out[1] and tmr_out[2]. Edges on the timers that are not selected are ignored.
- R3: Selector 3'b011 behaves exactly like 3'b010 (tmr_out[2]). tmr_out[1] has no effect under that code.
- R4: Selector 3'b100 uses cnv_pin after a two-flop synchronizer, so the sequence starts two cycles later than it would from a timer. Selector 3'b101 inverts the synchronized pin before edge detection, so a falling pin starts the sequence.
- R5: With adc_en low no request is acted on. Dropping adc_en during a sequence returns the block to idle on the next edge, with no done pulse.
- R6: One-edge sequence from a shut-down converter: pwr_up is high for T_PWRUP cycles, then acquire for T_ACQ, then convert for T_CONV. After that, done is high for exactly one cycle, with busy already low.
- R7: In two-edge mode (mode_dual=1), a rising request gives pwr_up for T_PWRUP cycles and then holds acquire until a falling request arrives. That falling edge gives T_CONV cycles of convert and then done. A falling edge that arrives during wake-up is remembered, and conversion follows wake-up directly.
- R8: mode_dual=1 together with gain_code 0 (gain 1; every nonzero code means gain above 1) is illegal. It raises cfg_err from the next cycle for as long as it lasts, and no request starts a sequence meanwhile.
- R9: Selector 3'b110 starts only on a src_wr pulse. A new conversion then starts every PER_UNITY (16) cycles with gain_code 0, or every PER_GAIN (56) cycles otherwise. Only the first conversion has a wake-up phase. Leaving the code stops the pacing and shuts the converter down.
- R10: Selector 3'b111 starts one full one-edge sequence per sw_start pulse. Software and continuous starts ignore mode_dual.
- R11: Start requests that arrive while busy is high are dropped and produce no extra sequence.
- R12: At most one of pwr_up, acquire and convert is high in any cycle, and busy is high exactly when one of them is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_en | input | 1 | Converter enable; requests are ignored while low |
| gain_code | input | GAIN_W | Gain setting; 0 means unity gain |
| mode_dual | input | 1 | 1 selects two-edge triggering |
| src_sel | input | 3 | Start-request source selector |
| src_wr | input | 1 | Pulse marking a write of src_sel (starts continuous mode) |
| tmr_out | input | N_TMR | Timer outputs used as start requests |
| cnv_pin | input | 1 | Asynchronous external convert pin |
| sw_start | input | 1 | Pulse marking a write of the software start bit |
| pwr_up | output | 1 | Converter wake-up phase |
| acquire | output | 1 | Acquisition (tracking) phase |
| convert | output | 1 | Sample and conversion phase |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a conversion finishes |
| cfg_err | output | 1 | Illegal two-edge plus unity-gain setting |

## Verification
The checker watches on every cycle that the three phase strobes are mutually exclusive and that busy matches them. It also checks that done is a single-cycle pulse that only follows convert, and that conversion is only ever entered from wake-up or acquisition. It further covers that a disabled or misconfigured block never becomes busy and that cfg_err follows the illegal setting. The choice of source and the reserved-code alias, the two extra synchronizer cycles on the pin and its inversion, the held acquisition in two-edge mode and the continuous pacing periods can only be shown by the bench's directed scenarios. The same holds for skipping wake-up while the converter stays awake. The bench measures these against its cycle model.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PWR  = 3'd1,
    PH_ACQ  = 3'd2,
    PH_HOLD = 3'd3,
    PH_CONV = 3'd4
  } phase_t;

  localparam logic [2:0] SEL_PIN     = 3'b100;
  localparam logic [2:0] SEL_PIN_INV = 3'b101;
  localparam logic [2:0] SEL_CONT    = 3'b110;
  localparam logic [2:0] SEL_SW      = 3'b111;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/adc_trig_select.sv
module adc_trig_select #(
  parameter int N_TMR       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       sel,
  input  logic [N_TMR-1:0] tmr,
  input  logic             pin,
  output logic             rise,
  output logic             fall,
  output logic             edge_src
);
  localparam int LAST_TMR = N_TMR - 1;

  logic [3:0] tmr_map;
  logic       pin_s;
  logic       lev;
  logic       lev_q;

  // codes above the last timer alias onto the last timer
  for (genvar i = 0; i < 4; i++) begin : g_map
    localparam int IDX = (i < N_TMR) ? i : LAST_TMR;
    assign tmr_map[i] = tmr[IDX];
  end

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin),
    .q   (pin_s)
  );

  always_comb begin
    if (!sel[2])      lev = tmr_map[sel[1:0]];
    else if (!sel[1]) lev = pin_s ^ sel[0];
    else              lev = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) lev_q <= 1'b0;
    else     lev_q <= lev;
  end

  assign rise     = lev & ~lev_q;
  assign fall     = ~lev & lev_q;
  assign edge_src = ~(sel[2] & sel[1]);
endmodule

// File: rtl/adc_trig_pacer.sv
module adc_trig_pacer #(
  parameter int PER_UNITY = 16,
  parameter int PER_GAIN  = 56
) (
  input  logic clk,
  input  logic rst,
  input  logic en_ok,
  input  logic sel_cont,
  input  logic wr,
  input  logic unity,
  output logic run,
  output logic tick
);
  localparam int PMAX = (PER_UNITY > PER_GAIN) ? PER_UNITY : PER_GAIN;
  localparam int CW   = $clog2(PMAX + 1);
  localparam logic [CW-1:0] LAST_U = CW'(PER_UNITY - 1);
  localparam logic [CW-1:0] LAST_G = CW'(PER_GAIN - 1);

  logic [CW-1:0] cnt;
  logic          run_q;
  logic          start;
  logic          keep;
  logic          wrap;

  assign start = wr & sel_cont & en_ok;
  assign keep  = sel_cont & en_ok;
  assign wrap  = cnt >= (unity ? LAST_U : LAST_G);
  assign tick  = start | (run_q & keep & wrap);
  assign run   = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt   <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt   <= '0;
    end else if (!keep) begin
      run_q <= 1'b0;
      cnt   <= '0;
    end else if (run_q) begin
      cnt   <= wrap ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_trig_fsm.sv
module adc_trig_fsm
  import adc_trig_pkg::*;
#(
  parameter int T_PWRUP = 4,
  parameter int T_ACQ   = 3,
  parameter int T_CONV  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic go_full,
  input  logic go_split,
  input  logic fall,
  input  logic keep_warm,
  output logic pwr_up,
  output logic acquire,
  output logic convert,
  output logic busy,
  output logic done
);
  localparam int TMAX = max3(T_PWRUP, T_ACQ, T_CONV);
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] LD_PWR  = CW'(T_PWRUP - 1);
  localparam logic [CW-1:0] LD_ACQ  = CW'(T_ACQ - 1);
  localparam logic [CW-1:0] LD_CONV = CW'(T_CONV - 1);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          warm_q, warm_d;
  logic          split_q, split_d;
  logic          fp_q, fp_d;
  logic          done_d;
  logic          hot;

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    warm_d  = warm_q;
    split_d = split_q;
    fp_d    = fp_q;
    done_d  = 1'b0;
    hot     = warm_q & keep_warm;
    if (!en) begin
      ph_d    = PH_IDLE;
      warm_d  = 1'b0;
      fp_d    = 1'b0;
      split_d = 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          warm_d = hot;
          if (go_full) begin
            split_d = 1'b0;
            if (hot) begin
              ph_d  = PH_ACQ;
              cnt_d = LD_ACQ;
            end else begin
              ph_d  = PH_PWR;
              cnt_d = LD_PWR;
            end
          end else if (go_split) begin
            split_d = 1'b1;
            fp_d    = 1'b0;
            if (hot) begin
              ph_d = PH_HOLD;
            end else begin
              ph_d  = PH_PWR;
              cnt_d = LD_PWR;
            end
          end
        end
        PH_PWR: begin
          if (cnt_q == '0) begin
            warm_d = 1'b1;
            if (split_q) begin
              if (fp_q | fall) begin
                ph_d  = PH_CONV;
                cnt_d = LD_CONV;
              end else begin
                ph_d = PH_HOLD;
              end
            end else begin
              ph_d  = PH_ACQ;
              cnt_d = LD_ACQ;
            end
          end else begin
            if (split_q & fall) fp_d = 1'b1;
            cnt_d = cnt_q - 1'b1;
          end
        end
        PH_ACQ: begin
          if (cnt_q == '0) begin
            ph_d  = PH_CONV;
            cnt_d = LD_CONV;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (fall) begin
            ph_d  = PH_CONV;
            cnt_d = LD_CONV;
          end
        end
        PH_CONV: begin
          if (cnt_q == '0) begin
            ph_d   = PH_IDLE;
            done_d = 1'b1;
            warm_d = keep_warm;
            fp_d   = 1'b0;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      warm_q  <= 1'b0;
      split_q <= 1'b0;
      fp_q    <= 1'b0;
      pwr_up  <= 1'b0;
      acquire <= 1'b0;
      convert <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      warm_q  <= warm_d;
      split_q <= split_d;
      fp_q    <= fp_d;
      pwr_up  <= (ph_d == PH_PWR);
      acquire <= (ph_d == PH_ACQ) || (ph_d == PH_HOLD);
      convert <= (ph_d == PH_CONV);
      busy    <= (ph_d != PH_IDLE);
      done    <= done_d;
    end
  end
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_trig_pkg::*;
#(
  parameter int GAIN_W      = 3,
  parameter int N_TMR       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int T_PWRUP     = 4,
  parameter int T_ACQ       = 3,
  parameter int T_CONV      = 5,
  parameter int PER_UNITY   = 16,
  parameter int PER_GAIN    = 56
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adc_en,
  input  logic [GAIN_W-1:0] gain_code,
  input  logic              mode_dual,
  input  logic [2:0]        src_sel,
  input  logic              src_wr,
  input  logic [N_TMR-1:0]  tmr_out,
  input  logic              cnv_pin,
  input  logic              sw_start,
  output logic              pwr_up,
  output logic              acquire,
  output logic              convert,
  output logic              busy,
  output logic              done,
  output logic              cfg_err
);
  logic unity;
  logic bad_cfg;
  logic en_ok;
  logic rise, fall, edge_src;
  logic run, tick;
  logic go_edge, go_full, go_split;

  assign unity   = (gain_code == '0);
  assign bad_cfg = adc_en & mode_dual & unity;
  assign en_ok   = adc_en & ~bad_cfg;

  adc_trig_select #(.N_TMR(N_TMR), .SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .sel      (src_sel),
    .tmr      (tmr_out),
    .pin      (cnv_pin),
    .rise     (rise),
    .fall     (fall),
    .edge_src (edge_src)
  );

  adc_trig_pacer #(.PER_UNITY(PER_UNITY), .PER_GAIN(PER_GAIN)) u_pace (
    .clk      (clk),
    .rst      (rst),
    .en_ok    (en_ok),
    .sel_cont (src_sel == SEL_CONT),
    .wr       (src_wr),
    .unity    (unity),
    .run      (run),
    .tick     (tick)
  );

  assign go_edge  = rise & edge_src & en_ok;
  assign go_full  = (go_edge & ~mode_dual) | tick |
                    (sw_start & (src_sel == SEL_SW) & en_ok);
  assign go_split = go_edge & mode_dual;

  adc_trig_fsm #(.T_PWRUP(T_PWRUP), .T_ACQ(T_ACQ), .T_CONV(T_CONV)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .en        (adc_en),
    .go_full   (go_full),
    .go_split  (go_split),
    .fall      (fall & edge_src),
    .keep_warm (run),
    .pwr_up    (pwr_up),
    .acquire   (acquire),
    .convert   (convert),
    .busy      (busy),
    .done      (done)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= bad_cfg;
  end
endmodule

// File: rtl/adc_trig_seq_chk.sv
module adc_trig_seq_chk #(
  parameter int GAIN_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              adc_en,
  input logic              mode_dual,
  input logic [GAIN_W-1:0] gain_code,
  input logic              pwr_up,
  input logic              acquire,
  input logic              convert,
  input logic              busy,
  input logic              done,
  input logic              cfg_err
);
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pwr_up, acquire, convert})); // R12
  AST_BUSY_PHASE: assert property (@(posedge clk) disable iff (rst)
    busy == (pwr_up | acquire | convert)); // R12
  AST_DONE_AFTER_CONV: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(convert))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !adc_en |=> (!busy && !done)); // R5
  AST_BAD_NOSTART: assert property (@(posedge clk) disable iff (rst)
    (adc_en && mode_dual && gain_code == '0 && !busy) |=> !busy); // R8
  AST_BAD_FLAG: assert property (@(posedge clk) disable iff (rst)
    (adc_en && mode_dual && gain_code == '0) |=> cfg_err); // R8
  AST_CONV_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(convert) |-> $past(acquire || pwr_up)); // R7
endmodule

bind adc_trig_seq adc_trig_seq_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .adc_en    (adc_en),
  .mode_dual (mode_dual),
  .gain_code (gain_code),
  .pwr_up    (pwr_up),
  .acquire   (acquire),
  .convert   (convert),
  .busy      (busy),
  .done      (done),
  .cfg_err   (cfg_err)
);

// File: tb/adc_trig_seq_bench.sv
module adc_trig_seq_bench;
  localparam int TP = 4, TA = 3, TC = 5, PU = 16, PG = 56;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adc_en, mode_dual, src_wr, cnv_pin, sw_start;
  logic [2:0] gain_code, src_sel, tmr_out;
  logic pwr_up, acquire, convert, busy, done, cfg_err;

  always #10 clk = ~clk;

  adc_trig_seq u_adc_trig_seq (
    .clk(clk), .rst(rst), .adc_en(adc_en), .gain_code(gain_code),
    .mode_dual(mode_dual), .src_sel(src_sel), .src_wr(src_wr),
    .tmr_out(tmr_out), .cnv_pin(cnv_pin), .sw_start(sw_start),
    .pwr_up(pwr_up), .acquire(acquire), .convert(convert),
    .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural cycle model: phase 0 idle, 1 wake, 2 acquire, 3 held acquire, 4 convert
  int m_s1, m_s2, m_lev, m_ph, m_left, m_warm, m_dual, m_fp, m_run, m_pc;
  int e_pwr, e_acq, e_conv, e_busy, e_done, e_err;

  always @(posedge clk) begin : model
    int lev, rise, fall, badc, enok, tick, go1, go2, code, oldrun, hot, eok;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_lev = 0; m_ph = 0; m_left = 0; m_warm = 0;
      m_dual = 0; m_fp = 0; m_run = 0; m_pc = 0;
      e_pwr = 0; e_acq = 0; e_conv = 0; e_busy = 0; e_done = 0; e_err = 0;
    end else begin
      code = int'(src_sel);
      if (code < 4)       lev = int'(tmr_out[(code > 2) ? 2 : code]);
      else if (code == 4) lev = m_s2;
      else if (code == 5) lev = (m_s2 == 0) ? 1 : 0;
      else                lev = 0;
      rise = (lev == 1 && m_lev == 0) ? 1 : 0;
      fall = (lev == 0 && m_lev == 1) ? 1 : 0;
      m_lev = lev; m_s2 = m_s1; m_s1 = int'(cnv_pin);
      badc = (adc_en && mode_dual && gain_code == 0) ? 1 : 0;
      enok = (adc_en && badc == 0) ? 1 : 0;
      e_err = badc;
      oldrun = m_run;
      tick = 0;
      if (src_wr && code == 6 && enok == 1) begin m_run = 1; m_pc = 0; tick = 1; end
      else if (!(code == 6 && enok == 1)) begin m_run = 0; m_pc = 0; end
      else if (m_run == 1) begin
        if (m_pc >= ((gain_code == 0) ? PU : PG) - 1) begin tick = 1; m_pc = 0; end
        else m_pc++;
      end
      eok = (code < 6 && enok == 1) ? 1 : 0;
      go1 = (tick == 1 || (code == 7 && sw_start && enok == 1) ||
             (eok == 1 && rise == 1 && !mode_dual)) ? 1 : 0;
      go2 = (eok == 1 && rise == 1 && mode_dual) ? 1 : 0;
      if (code >= 6) fall = 0;
      e_done = 0;
      hot = (m_warm == 1 && oldrun == 1) ? 1 : 0;
      if (!adc_en) begin m_ph = 0; m_warm = 0; m_fp = 0; m_dual = 0; end
      else case (m_ph)
        0: begin
          m_warm = hot;
          if (go1 == 1) begin m_dual = 0; if (hot == 1) begin m_ph = 2; m_left = TA - 1; end
                                             else begin m_ph = 1; m_left = TP - 1; end end
          else if (go2 == 1) begin m_dual = 1; m_fp = 0;
            if (hot == 1) m_ph = 3; else begin m_ph = 1; m_left = TP - 1; end end
        end
        1: begin
          if (m_left == 0) begin
            m_warm = 1;
            if (m_dual == 1) begin
              if (m_fp == 1 || fall == 1) begin m_ph = 4; m_left = TC - 1; end else m_ph = 3;
            end else begin m_ph = 2; m_left = TA - 1; end
          end else begin
            if (m_dual == 1 && fall == 1) m_fp = 1;
            m_left--;
          end
        end
        2: if (m_left == 0) begin m_ph = 4; m_left = TC - 1; end else m_left--;
        3: if (fall == 1) begin m_ph = 4; m_left = TC - 1; end
        default: if (m_left == 0) begin m_ph = 0; e_done = 1; m_warm = oldrun; m_fp = 0; end
                 else m_left--;
      endcase
      e_pwr = (m_ph == 1) ? 1 : 0;
      e_acq = (m_ph == 2 || m_ph == 3) ? 1 : 0;
      e_conv = (m_ph == 4) ? 1 : 0;
      e_busy = (m_ph != 0) ? 1 : 0;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(int'(pwr_up) == e_pwr, "R6 pwr_up trace", int'(pwr_up), e_pwr);
      chk(int'(acquire) == e_acq, "R7 acquire trace", int'(acquire), e_acq);
      chk(int'(convert) == e_conv, "R6 convert trace", int'(convert), e_conv);
      chk(int'(busy) == e_busy, "R11 busy trace", int'(busy), e_busy);
      chk(int'(done) == e_done, "R6 done trace", int'(done), e_done);
      chk(int'(cfg_err) == e_err, "R8 cfg_err trace", int'(cfg_err), e_err);
      chk($countones({pwr_up, acquire, convert}) <= 1, "R12 phase exclusivity",
          $countones({pwr_up, acquire, convert}), 1);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int lat, output int np, output int na, output int nc);
    lat = 0; np = 0; na = 0; nc = 0;
    do begin
      @(negedge clk);
      lat++;
      np += int'(pwr_up); na += int'(acquire); nc += int'(convert);
    end while (!done && lat < 300);
  endtask

  task automatic watch(input int n, output int nd, output int nb);
    nd = 0; nb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      nd += int'(done); nb += int'(busy);
    end
  endtask

  initial begin : stim
    int lat, np, na, nc, nd, nb;
    adc_en = 1; mode_dual = 0; src_wr = 0; cnv_pin = 0; sw_start = 0;
    gain_code = 0; src_sel = 3'b000; tmr_out = 0;
    wait_n(3);
    rst = 0;
    wait_n(1);
    chk({pwr_up, acquire, convert, busy, done, cfg_err} == 6'b0, "R1 reset state",
        int'({pwr_up, acquire, convert, busy, done, cfg_err}), 0);

    // R2: unselected timer ignored, selected timers start
    tmr_out[1] = 1;
    watch(20, nd, nb);
    chk(nb == 0, "R2 unselected timer ignored", nb, 0);
    tmr_out = 0; wait_n(2);
    tmr_out[0] = 1;
    measure(lat, np, na, nc);
    chk(lat == TP + TA + TC + 1, "R2 timer0 latency", lat, TP + TA + TC + 1);
    chk(np == TP && na == TA && nc == TC, "R6 phase lengths", np * 100 + na * 10 + nc,
        TP * 100 + TA * 10 + TC);
    tmr_out = 0; wait_n(3);
    src_sel = 3'b001; wait_n(2);
    tmr_out[1] = 1;
    measure(lat, np, na, nc);
    chk(lat == TP + TA + TC + 1, "R2 timer1 latency", lat, TP + TA + TC + 1);
    tmr_out = 0; wait_n(3);
    src_sel = 3'b010; wait_n(2);
    tmr_out[2] = 1;
    measure(lat, np, na, nc);
    chk(lat == TP + TA + TC + 1, "R2 timer2 latency", lat, TP + TA + TC + 1);
    tmr_out = 0; wait_n(3);

    // R3: reserved code aliases timer 2
    src_sel = 3'b011; wait_n(2);
    tmr_out[1] = 1;
    watch(20, nd, nb);
    chk(nb == 0, "R3 timer1 ignored under 011", nb, 0);
    tmr_out = 0; wait_n(2);
    tmr_out[2] = 1;
    measure(lat, np, na, nc);
    chk(lat == TP + TA + TC + 1, "R3 011 follows timer2", lat, TP + TA + TC + 1);
    tmr_out = 0; wait_n(3);

    // R4: synchronized pin, plain and inverted
    src_sel = 3'b100; wait_n(2);
    cnv_pin = 1;
    measure(lat, np, na, nc);
    chk(lat == TP + TA + TC + 3, "R4 pin latency", lat, TP + TA + TC + 3);
    cnv_pin = 0; wait_n(6);
    adc_en = 0; cnv_pin = 1; wait_n(1);
    src_sel = 3'b101; wait_n(5);
    adc_en = 1; wait_n(2);
    cnv_pin = 0;
    measure(lat, np, na, nc);
    chk(lat == TP + TA + TC + 3, "R4 inverted pin falling start", lat, TP + TA + TC + 3);
    wait_n(3);
    src_sel = 3'b000; wait_n(3);

    // R5: enable gating and abort
    adc_en = 0; tmr_out[0] = 1;
    watch(20, nd, nb);
    chk(nb == 0, "R5 disabled ignores trigger", nb, 0);
    tmr_out = 0; adc_en = 1; wait_n(2);
    tmr_out[0] = 1; wait_n(5);
    chk(busy == 1'b1, "R5 sequence running before abort", int'(busy), 1);
    adc_en = 0;
    watch(15, nd, nb);
    chk(nb == 0 && nd == 0, "R5 abort no done", nb + nd, 0);
    tmr_out = 0; adc_en = 1; wait_n(3);

    // R11: second edge while busy dropped
    tmr_out[0] = 1; wait_n(3);
    tmr_out[0] = 0; wait_n(2);
    tmr_out[0] = 1; wait_n(1);
    tmr_out[0] = 0;
    watch(30, nd, nb);
    chk(nd == 1, "R11 edge while busy ignored", nd, 1);

    // R7: two-edge mode, held acquisition
    gain_code = 3'd2; mode_dual = 1; wait_n(2);
    tmr_out[0] = 1;
    watch(20, nd, nb);
    chk(nd == 0 && acquire == 1'b1, "R7 acquisition held", int'(acquire), 1);
    tmr_out[0] = 0;
    measure(lat, np, na, nc);
    chk(lat == TC + 1 && nc == TC, "R7 fall starts conversion", lat, TC + 1);
    wait_n(3);
    tmr_out[0] = 1; wait_n(2);
    tmr_out[0] = 0;
    measure(lat, np, na, nc);
    chk(lat == TP + TC - 1 && na == 0, "R7 fall during wake-up", lat * 10 + na,
        (TP + TC - 1) * 10);
    wait_n(3);

    // R8: illegal two-edge with unity gain
    gain_code = 0; wait_n(1);
    chk(cfg_err == 1'b1, "R8 cfg_err raised", int'(cfg_err), 1);
    tmr_out[0] = 1;
    watch(15, nd, nb);
    chk(nb == 0, "R8 trigger blocked", nb, 0);
    tmr_out = 0; wait_n(2);
    mode_dual = 0; wait_n(2);
    chk(cfg_err == 1'b0, "R8 cfg_err clears", int'(cfg_err), 0);

    // R10: software start ignores mode bit, busy drops repeat
    gain_code = 3'd2; mode_dual = 1; src_sel = 3'b111; wait_n(2);
    sw_start = 1; wait_n(1); sw_start = 0;
    measure(lat, np, na, nc);
    chk(lat == TP + TA + TC && na == TA, "R10 software full sequence", lat, TP + TA + TC);
    wait_n(2);
    sw_start = 1; wait_n(1); sw_start = 0;
    wait_n(4);
    sw_start = 1; wait_n(1); sw_start = 0;
    watch(30, nd, nb);
    chk(nd == 1, "R11 software start while busy ignored", nd, 1);

    // R9: continuous pacing
    mode_dual = 0; gain_code = 0; src_sel = 3'b110;
    watch(20, nd, nb);
    chk(nb == 0, "R9 no start without write", nb, 0);
    src_wr = 1; wait_n(1); src_wr = 0;
    measure(lat, np, na, nc);
    chk(lat == TP + TA + TC && np == TP - 1, "R9 first conversion cold", lat, TP + TA + TC);
    measure(lat, np, na, nc);
    chk(lat == PU - TP && np == 0, "R9 warm conversion skips wake-up", lat, PU - TP);
    measure(lat, np, na, nc);
    chk(lat == PU, "R9 unity period", lat, PU);
    src_sel = 3'b000;
    watch(60, nd, nb);
    chk(nd == 0, "R9 stop on code change", nd, 0);
    gain_code = 3'd2; src_sel = 3'b110; wait_n(1);
    src_wr = 1; wait_n(1); src_wr = 0;
    measure(lat, np, na, nc);
    chk(np == TP - 1, "R9 shut down after stop", np, TP - 1);
    measure(lat, np, na, nc);
    chk(lat == PG - TP, "R9 gain first interval", lat, PG - TP);
    measure(lat, np, na, nc);
    chk(lat == PG, "R9 gain period", lat, PG);
    src_sel = 3'b000; wait_n(20);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule